// File: doc/BRIEF.md
# Power-Fail SRAM Write-Protect Controller

This block sits between a processor's active-low chip-enable and two banks of static RAM. While supply power is good, it steers the chip-enable onto one of two active-low bank enables, using a bank-select bit. That path is combinational, so it adds no clock latency. An external comparator reports supply health as a power-good flag, and the block resynchronizes that flag with a two-stage flop chain.

When power goes bad, the block write-protects both banks. There are two cases:
- If no access is under way, protection starts on the next clock edge.
- If an access is under way, the bank it targets is allowed to finish. A cycle-count timeout limits how long that can take.

Once protection has begun, both enables stay inactive for as long as power stays bad. When power returns, two separate counters run. One holds the bank enables inactive for a fixed number of cycles. The other holds the active-high system reset for its own number of cycles. If power fails again during either hold, that hold starts over. All timing parameters are given in clock cycles. Their defaults assume a 200 MHz clock.

Top module: `pf_wp_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `bank_en_n` is `2'b11` and `sys_rst` is 1, whatever `ce_n` and `bank_sel` do.
- R2: Whenever `ce_n` is 1, `bank_en_n` is `2'b11`.
- R3: In normal operation with `ce_n` = 0, `bank_sel` = 0 gives `bank_en_n` = `2'b10` (bit 0 is bank 1), and `bank_sel` = 1 gives `2'b01`. Both follow the inputs in the same cycle.
- R4: If `pwr_ok_in` falls while `ce_n` is 1, `bank_en_n` is held at `2'b11` from the third rising edge after the fall onward. The edges are counted from the first edge at which the low input is sampled.
- R5: If `ce_n` is 0 at that third edge, the access is an in-flight access. It keeps driving the bank that was selected at that edge, and later changes of `bank_sel` are ignored.
- R6: Once an in-flight access ends (`ce_n` returns to 1), both enables stay at 1 until power is good again. This holds even if `ce_n` goes low again.
- R7: An in-flight access that is still running is cut off: `bank_en_n` becomes `2'b11` at edge `3 + WP_TIMEOUT_CYC`.
- R8: Counting edges from the first at which a high `pwr_ok_in` is sampled, `bank_en_n` stays `2'b11` through edge `EN_HOLD_CYC + 2`. Pass-through resumes after edge `EN_HOLD_CYC + 3`.
- R9: If power is lost during the enable hold, the hold restarts. Counting from the edge at which power is again sampled good, pass-through resumes after edge `EN_HOLD_CYC + 3`.
- R10: After a power loss from normal operation, `sys_rst` rises at edge `3 + RST_DELAY_CYC`.
- R11: `sys_rst` falls at edge `RST_HOLD_CYC + 2`, counted from the first edge at which a high `pwr_ok_in` is sampled. Any bad-power sample during that hold restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, period known to the timing parameters |
| rst | input | 1 | Synchronous active-high block reset |
| pwr_ok_in | input | 1 | Power-good flag from the supply comparator, asynchronous |
| ce_n | input | 1 | Active-low chip-enable from the processor |
| bank_sel | input | 1 | Bank select: 0 for bank 1, 1 for bank 2 |
| bank_en_n | output | 2 | Conditioned active-low bank enables; bit 0 is bank 1, bit 1 is bank 2 |
| sys_rst | output | 1 | Active-high system reset |

## Verification
An internal state error shows up at the enable pins in the very cycle it appears, because the state register gates the combinational pass-through. A guard that wrongly sits in normal operation during bad power lets a low `ce_n` through. A guard stuck in a hold blocks every access. A drain that fails to end shows as an enable held low past the timeout edge. Latching the wrong bank shows as the other bank's enable going low right after detection. Errors in the reset counter show at `sys_rst` as an early or late edge, offset by the counter error in cycles. The bench therefore checks the pins at every edge around each transition.

// File: rtl/pf_wp_pkg.sv
package pf_wp_pkg;

    localparam int unsigned NUM_BANKS = 2;

    typedef enum logic [1:0] {
        GS_PROT  = 2'd0,
        GS_HOLD  = 2'd1,
        GS_RUN   = 2'd2,
        GS_DRAIN = 2'd3
    } guard_state_e;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_PEND   = 2'd1,
        RS_ACTIVE = 2'd2
    } rst_state_e;

    typedef enum logic [1:0] {
        GATE_BLOCK   = 2'd0,
        GATE_LIVE    = 2'd1,
        GATE_LATCHED = 2'd2
    } gate_mode_e;

    typedef struct packed {
        gate_mode_e mode;
        logic       bank;
    } gate_ctl_t;

    // Bits needed for a counter running 0 .. n-1
    function automatic int unsigned cnt_width(input int unsigned n);
        if (n < 2) return 1;
        return $clog2(n);
    endfunction

    // Steer an active-low enable onto the chosen bank
    function automatic logic [NUM_BANKS-1:0] bank_decode(input logic ce_n, input logic sel);
        logic [NUM_BANKS-1:0] v;
        v = '1;
        if (!ce_n) v[sel] = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pf_guard_fsm.sv
module pf_guard_fsm
    import pf_wp_pkg::*;
#(
    parameter int unsigned TO_CYC   = 30000,
    parameter int unsigned HOLD_CYC = 20000000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pv_ok,
    input  logic         ce_n,
    input  logic         bank_sel,
    output gate_ctl_t    gate,
    output guard_state_e state
);
    localparam int unsigned MAXC = (TO_CYC > HOLD_CYC) ? TO_CYC : HOLD_CYC;
    localparam int unsigned CW   = cnt_width(MAXC);
    localparam logic [CW-1:0] TO_LAST   = CW'(TO_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

    guard_state_e st;
    logic [CW-1:0] cnt;
    logic          lat_bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= GS_PROT;
            cnt      <= '0;
            lat_bank <= 1'b0;
        end else begin
            case (st)
                GS_PROT: begin
                    if (pv_ok) begin
                        st  <= GS_HOLD;
                        cnt <= '0;
                    end
                end
                GS_HOLD: begin
                    if (!pv_ok) begin
                        st <= GS_PROT;
                    end else if (cnt == HOLD_LAST) begin
                        st <= GS_RUN;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                GS_RUN: begin
                    if (!pv_ok) begin
                        cnt <= '0;
                        if (!ce_n) begin
                            st       <= GS_DRAIN;
                            lat_bank <= bank_sel;
                        end else begin
                            st <= GS_PROT;
                        end
                    end
                end
                GS_DRAIN: begin
                    if (ce_n || cnt == TO_LAST) begin
                        st <= GS_PROT;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: st <= GS_PROT;
            endcase
        end
    end

    always_comb begin
        gate.bank = lat_bank;
        case (st)
            GS_RUN:   gate.mode = GATE_LIVE;
            GS_DRAIN: gate.mode = GATE_LATCHED;
            default:  gate.mode = GATE_BLOCK;
        endcase
    end

    assign state = st;
endmodule

// File: rtl/pf_reset_gen.sv
module pf_reset_gen
    import pf_wp_pkg::*;
#(
    parameter int unsigned DLY_CYC  = 20000,
    parameter int unsigned HOLD_CYC = 16000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pv_ok,
    output logic       sys_rst,
    output rst_state_e state
);
    localparam int unsigned MAXC = (DLY_CYC > HOLD_CYC) ? DLY_CYC : HOLD_CYC;
    localparam int unsigned CW   = cnt_width(MAXC);
    localparam logic [CW-1:0] DLY_LAST  = CW'(DLY_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

    rst_state_e    st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= RS_ACTIVE;
            cnt <= '0;
        end else begin
            case (st)
                RS_ACTIVE: begin
                    if (!pv_ok) begin
                        cnt <= '0;
                    end else if (cnt == HOLD_LAST) begin
                        st  <= RS_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                RS_IDLE: begin
                    if (!pv_ok) begin
                        st  <= RS_PEND;
                        cnt <= '0;
                    end
                end
                RS_PEND: begin
                    if (cnt == DLY_LAST) begin
                        st  <= RS_ACTIVE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: st <= RS_ACTIVE;
            endcase
        end
    end

    assign sys_rst = (st == RS_ACTIVE);
    assign state   = st;
endmodule

// File: rtl/pf_wp_ctrl.sv
module pf_wp_ctrl
    import pf_wp_pkg::*;
#(
    parameter int unsigned WP_TIMEOUT_CYC = 30000,
    parameter int unsigned EN_HOLD_CYC    = 20000000,
    parameter int unsigned RST_DELAY_CYC  = 20000,
    parameter int unsigned RST_HOLD_CYC   = 16000000,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_ok_in,
    input  logic       ce_n,
    input  logic       bank_sel,
    output logic [1:0] bank_en_n,
    output logic       sys_rst
);
    logic         pv_sync;
    gate_ctl_t    gate;
    guard_state_e g_state;
    rst_state_e   r_state;

    pf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pwr_ok_in),
        .q   (pv_sync)
    );

    pf_guard_fsm #(
        .TO_CYC   (WP_TIMEOUT_CYC),
        .HOLD_CYC (EN_HOLD_CYC)
    ) u_guard (
        .clk      (clk),
        .rst      (rst),
        .pv_ok    (pv_sync),
        .ce_n     (ce_n),
        .bank_sel (bank_sel),
        .gate     (gate),
        .state    (g_state)
    );

    pf_reset_gen #(
        .DLY_CYC  (RST_DELAY_CYC),
        .HOLD_CYC (RST_HOLD_CYC)
    ) u_rstgen (
        .clk     (clk),
        .rst     (rst),
        .pv_ok   (pv_sync),
        .sys_rst (sys_rst),
        .state   (r_state)
    );

    // Combinational pass-through, gated by the registered guard state
    always_comb begin
        case (gate.mode)
            GATE_LIVE:    bank_en_n = bank_decode(ce_n, bank_sel);
            GATE_LATCHED: bank_en_n = bank_decode(ce_n, gate.bank);
            default:      bank_en_n = '1;
        endcase
    end
endmodule

// File: rtl/pf_wp_ctrl_chk.sv
module pf_wp_ctrl_chk
    import pf_wp_pkg::*;
#(
    parameter int unsigned TO_CYC = 30000
) (
    input logic         clk,
    input logic         rst,
    input logic         pv_ok,
    input logic         ce_n,
    input guard_state_e gstate,
    input rst_state_e   rstate,
    input logic [1:0]   bank_en_n,
    input logic         sys_rst
);
    logic [31:0] drain_run;

    always_ff @(posedge clk) begin
        if (rst)                    drain_run <= '0;
        else if (gstate == GS_DRAIN) drain_run <= drain_run + 32'd1;
        else                        drain_run <= '0;
    end

    p_ce_high_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> bank_en_n == 2'b11);

    p_single_bank_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bank_en_n));

    p_idle_loss_r4: assert property (@(posedge clk) disable iff (rst)
        (gstate == GS_RUN && !pv_ok && ce_n) |=> gstate == GS_PROT);

    p_drain_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (gstate == GS_DRAIN && ce_n) |=> gstate == GS_PROT);

    p_prot_stays_r6: assert property (@(posedge clk) disable iff (rst)
        (gstate == GS_PROT && !pv_ok) |=> gstate == GS_PROT);

    p_prot_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        gstate == GS_PROT |-> bank_en_n == 2'b11);

    p_drain_bound_r7: assert property (@(posedge clk) disable iff (rst)
        drain_run <= 32'(TO_CYC));

    p_hold_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        gstate == GS_HOLD |-> bank_en_n == 2'b11);

    p_hold_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (gstate == GS_HOLD && !pv_ok) |=> gstate == GS_PROT);

    p_rst_kept_r11: assert property (@(posedge clk) disable iff (rst)
        (rstate == RS_ACTIVE && !pv_ok) |=> sys_rst);
endmodule

bind pf_wp_ctrl pf_wp_ctrl_chk #(.TO_CYC(WP_TIMEOUT_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pv_ok     (pv_sync),
    .ce_n      (ce_n),
    .gstate    (g_state),
    .rstate    (r_state),
    .bank_en_n (bank_en_n),
    .sys_rst   (sys_rst)
);

// File: tb/pf_wp_ctrl_bench.sv
`timescale 1ns/1ps
module pf_wp_ctrl_bench;
    localparam int TO = 6;
    localparam int H  = 5;
    localparam int RD = 3;
    localparam int RH = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst = 1'b1;
    logic       pwr_ok = 1'b0;
    logic       ce_n = 1'b1;
    logic       bank_sel = 1'b0;
    logic [1:0] en;
    logic       srst;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    pf_wp_ctrl #(
        .WP_TIMEOUT_CYC (TO),
        .EN_HOLD_CYC    (H),
        .RST_DELAY_CYC  (RD),
        .RST_HOLD_CYC   (RH),
        .SYNC_STAGES    (2)
    ) u_pf_wp_ctrl (
        .clk       (clk),
        .rst       (rst),
        .pwr_ok_in (pwr_ok),
        .ce_n      (ce_n),
        .bank_sel  (bank_sel),
        .bank_en_n (en),
        .sys_rst   (srst)
    );

    function automatic logic [1:0] want(input logic c, input logic s);
        if (c) return 2'b11;
        return s ? 2'b01 : 2'b10;
    endfunction

    task automatic chk_en(input string req, input logic [1:0] exp);
        checks++;
        if (en !== exp) begin
            fails++;
            $display("FAIL %s bank_en_n=%b expected=%b t=%0t", req, en, exp, $time);
        end
    endtask

    task automatic chk_rst(input string req, input logic exp);
        checks++;
        if (srst !== exp) begin
            fails++;
            $display("FAIL %s sys_rst=%b expected=%b t=%0t", req, srst, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic bring_up();
        @(negedge clk);
        ce_n   = 1'b1;
        pwr_ok = 1'b1;
        repeat (RH + H + 4) step();
    endtask

    task automatic go_down_idle();
        @(negedge clk);
        ce_n   = 1'b1;
        pwr_ok = 1'b0;
        repeat (3 + RD + 1) step();
    endtask

    initial begin
        #(5.0 * 50000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired t=%0t", $time);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state with an active chip-enable presented
        ce_n = 1'b0;
        repeat (3) step();
        chk_en("R1", 2'b11);
        chk_rst("R1", 1'b1);
        @(negedge clk);
        rst = 1'b0;
        step();
        chk_en("R1", 2'b11);
        chk_rst("R1", 1'b1);

        // R8 / R11: first power-up, ce low on bank 1 throughout
        @(negedge clk);
        pwr_ok = 1'b1; ce_n = 1'b0; bank_sel = 1'b0;
        for (int k = 1; k <= RH + 3; k++) begin
            step();
            chk_en("R8", (k >= H + 3) ? 2'b10 : 2'b11);
            chk_rst("R11", (k >= RH + 2) ? 1'b0 : 1'b1);
        end

        // R2 / R3: decode sweep in normal operation
        for (int c = 0; c < 2; c++) begin
            for (int s = 0; s < 2; s++) begin
                @(negedge clk);
                ce_n = c[0]; bank_sel = s[0];
                #1;
                chk_en(c == 1 ? "R2" : "R3", want(c[0], s[0]));
            end
        end

        // R4 / R10: power loss with no access in flight
        @(negedge clk);
        ce_n = 1'b1; pwr_ok = 1'b0;
        for (int k = 1; k <= 3 + RD + 1; k++) begin
            step();
            chk_rst("R10", (k >= 3 + RD) ? 1'b1 : 1'b0);
            if (k >= 3) begin
                ce_n = 1'b0;
                #0.5;
                chk_en("R4", 2'b11);
                ce_n = 1'b1;
            end
        end
        bring_up();

        // R5 / R7: in-flight access runs into the timeout, on each bank
        for (int b = 0; b < 2; b++) begin
            @(negedge clk);
            ce_n = 1'b0; bank_sel = b[0]; pwr_ok = 1'b0;
            for (int k = 1; k <= 3 + TO + 1; k++) begin
                step();
                if (k < 3 + TO) chk_en("R5", want(1'b0, b[0]));
                else            chk_en("R7", 2'b11);
                if (k == 3) bank_sel = ~b[0];
            end
            bring_up();
        end

        // R6: in-flight access ends early at each offset, on each bank
        for (int b = 0; b < 2; b++) begin
            for (int off = 0; off < TO; off++) begin
                @(negedge clk);
                ce_n = 1'b0; bank_sel = b[0]; pwr_ok = 1'b0;
                repeat (3 + off) step();
                chk_en("R5", want(1'b0, b[0]));
                @(negedge clk);
                ce_n = 1'b1;
                #1;
                chk_en("R6", 2'b11);
                @(negedge clk);
                ce_n = 1'b0;
                #1;
                chk_en("R6", 2'b11);
                step();
                chk_en("R6", 2'b11);
                bring_up();
            end
        end

        // R9 / R11: power glitch during the hold windows restarts them
        for (int j = 3; j < H; j++) begin
            go_down_idle();
            @(negedge clk);
            pwr_ok = 1'b1; ce_n = 1'b0; bank_sel = 1'b0;
            for (int k = 1; k <= j; k++) begin
                step();
                chk_en("R8", 2'b11);
            end
            @(negedge clk);
            pwr_ok = 1'b0;
            step();
            @(negedge clk);
            pwr_ok = 1'b1;
            for (int m = 1; m <= RH + 3; m++) begin
                step();
                chk_en("R9", (m >= H + 3) ? 2'b10 : 2'b11);
                chk_rst("R11", (m >= RH + 2) ? 1'b0 : 1'b1);
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule